// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block turns a large bank of general-purpose inputs into a small, fixed set of interrupt lines. Eight channels are shared among all pins. Each channel holds an 8-bit pin code that chooses one pin from the bank, a trigger mode (level or edge) and a sense (high/rising or low/falling). The pin inputs pass through a two-stage synchroniser. After that, each channel can apply a glitch filter of its own before the trigger logic sees the signal.

A level channel drives its output for as long as the filtered pin sits at its active value. An edge channel latches the event into a sticky pending bit, and that bit drives the output until software writes a 1 to the matching bit of the clear register. A channel can watch only one edge direction. To catch both edges of one pin, software points two channels at that pin and gives them opposite senses. Any write to a channel's pin code or its mode bits drops that channel's pending bit and reseeds its edge history from the newly chosen pin, so a reconfiguration never produces an event of its own.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, offset 0x00 reads 0, offsets 0x04 and 0x08 read 0xFFFFFFFF, offset 0x0C reads 0, and every interrupt output is low.
- R2: Offset 0x00 stores only bits 7:0 (bit n = channel n edge mode) and bits 23:16 (bit 16+n = channel n low/falling sense). Offset 0x0C stores only bits 23:0. The write-only clear register at 0x10 reads 0. Unstored bits read 0.
- R3: The pin code of channel n sits at bits 8*(n mod 4)+7 : 8*(n mod 4) of offset 0x04 for n<4 and of offset 0x08 for n≥4. A code of 0xFF, or any code not below the pin count, disables the channel, and its output stays low.
- R4: In level mode the output equals the filtered pin XOR the sense bit. Without filtering, a pin change shows at the output three clock edges after it is applied.
- R5: In edge mode the selected edge sets a pending bit that drives the output four clock edges after the pin change. The bit stays set after the pin returns.
- R6: Writing offset 0x10 clears pending bit n for each data bit n that is 1. Bits that are 0 leave their channels untouched.
- R7: Two channels set to the same pin, one falling and one rising, each report only their own edge.
- R8: Channel n's filter length k is bits 3n+2 : 3n of offset 0x0C, and 0 bypasses the filter. For k≥1 the filtered value changes only after k consecutive synchronised samples differ from it. A pulse shorter than k samples never reaches the output, and with k≥1 a held change appears 2+k edges after it is applied.
- R9: A write to offset 0x00, or to the select register that holds a channel's code, clears that channel's pending bit and reseeds its history from the new pin, so switching to a pin that is already high causes no rising-edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read enable; read data is 0 when low |
| reg_addr | input | 5 | Byte address; bits 1:0 must be 0 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| gpio_in | input | NUM_PINS | Asynchronous pin bank |
| irq_out | output | 8 | Per-channel interrupt lines |

## Verification
The bench builds the router with NUM_PINS set to 16. With that value, codes from 16 to 254 are legal 8-bit codes that name no pin, so the out-of-range disable path gets exercised as well as the reserved 0xFF code. The small bank keeps the stimulus readable. The directed tests place channels in both select registers, use filter lengths above and below a short pulse, and switch a pin code between a low pin and a high pin to cover the reseed rule.

// File: rtl/gir_pkg.sv
// Shared constants and types for the GPIO interrupt router.
// Assumes a fixed map of eight channels with 8-bit pin codes.
package gir_pkg;
    localparam int NCH    = 8;
    localparam int SEL_W  = 8;
    localparam int FILT_W = 3;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam logic [SEL_W-1:0] SEL_OFF = 8'hFF;

    typedef enum logic [2:0] {
        RA_MODE   = 3'd0,
        RA_SEL_LO = 3'd1,
        RA_SEL_HI = 3'd2,
        RA_FILT   = 3'd3,
        RA_CLR    = 3'd4
    } reg_idx_e;

    typedef struct packed {
        logic              edge_mode;
        logic              act_low;
        logic [SEL_W-1:0]  pin;
        logic [FILT_W-1:0] filt;
    } ch_cfg_t;
endpackage

// File: rtl/gir_regs.sv
// Register file of the router: mode, two select words, filter word, clear strobe.
// Assumes word-aligned accesses; a misaligned access is ignored.
module gir_regs
    import gir_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic                   rd,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    output ch_cfg_t [NCH-1:0]      cfg_o,
    output logic [NCH-1:0]         touch_o,
    output logic [NCH-1:0]         clr_o
);
    localparam int HALF = NCH / 2;

    logic [NCH-1:0]             mode_edge;
    logic [NCH-1:0]             mode_low;
    logic [NCH-1:0][SEL_W-1:0]  sel_q;
    logic [NCH-1:0][FILT_W-1:0] filt_q;
    reg_idx_e                   idx;
    logic                       aligned;
    logic                       wr_ok;

    assign idx     = reg_idx_e'(addr[4:2]);
    assign aligned = (addr[1:0] == 2'b00);
    assign wr_ok   = wr && aligned;

    // Configuration storage, loaded by writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_edge <= '0;
            mode_low  <= '0;
            sel_q     <= {NCH{SEL_OFF}};
            filt_q    <= '0;
        end else if (wr_ok) begin
            case (idx)
                RA_MODE: begin
                    mode_edge <= wdata[NCH-1:0];
                    mode_low  <= wdata[16 +: NCH];
                end
                RA_SEL_LO: begin
                    for (int c = 0; c < HALF; c++) sel_q[c] <= wdata[SEL_W*c +: SEL_W];
                end
                RA_SEL_HI: begin
                    for (int c = 0; c < HALF; c++) sel_q[c+HALF] <= wdata[SEL_W*c +: SEL_W];
                end
                RA_FILT: begin
                    for (int c = 0; c < NCH; c++) filt_q[c] <= wdata[FILT_W*c +: FILT_W];
                end
                default: ;
            endcase
        end
    end

    // Per-channel views: configuration bundle and reconfiguration strobe.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam reg_idx_e MY_SEL = (c < HALF) ? RA_SEL_LO : RA_SEL_HI;
        assign cfg_o[c]   = '{edge_mode: mode_edge[c], act_low: mode_low[c],
                              pin: sel_q[c], filt: filt_q[c]};
        assign touch_o[c] = wr_ok && (idx == RA_MODE || idx == MY_SEL);
    end

    // Clear strobes, one cycle wide.
    always_comb begin
        clr_o = '0;
        if (wr_ok && idx == RA_CLR) clr_o = wdata[NCH-1:0];
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (rd && aligned) begin
            case (idx)
                RA_MODE:   rdata = {8'h00, mode_low, 8'h00, mode_edge};
                RA_SEL_LO: rdata = sel_q[HALF-1:0];
                RA_SEL_HI: rdata = sel_q[NCH-1:HALF];
                RA_FILT:   rdata = {8'h00, filt_q};
                default:   rdata = '0;
            endcase
        end
    end

    // Mode bits move only on a write to offset 0x00.
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ok && idx == RA_MODE) |=> ($stable(mode_edge) && $stable(mode_low)));
endmodule

// File: rtl/gir_sync.sv
// Multi-stage synchroniser for a bank of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is implied.
module gir_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw bank through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gir_channel.sv
// One router channel: pin mux, glitch filter, edge history, pending bit, output.
// Assumes pins_s is already synchronous and NUM_PINS does not exceed 256.
module gir_channel
    import gir_pkg::*;
#(
    parameter int NUM_PINS = 255
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_s,
    input  ch_cfg_t             cfg,
    input  logic                touch,
    input  logic                clr,
    output logic                irq
);
    localparam int PAD = 1 << SEL_W;

    logic [PAD-1:0]    pins_ext;
    logic              en;
    logic              raw;
    logic              qual_q;
    logic              prev_q;
    logic              seed_q;
    logic              pend_q;
    logic [FILT_W-1:0] cnt_q;
    logic [FILT_W:0]   cnt_nx;
    logic              evt;

    assign pins_ext = PAD'(pins_s);
    assign en       = (cfg.pin != SEL_OFF) && (32'(cfg.pin) < 32'(NUM_PINS));
    assign raw      = en && pins_ext[cfg.pin];
    assign cnt_nx   = {1'b0, cnt_q} + 1'b1;

    // Reseed flag: set for one cycle after a reconfiguration write.
    always_ff @(posedge clk) begin
        if (!rst_n) seed_q <= 1'b1;
        else        seed_q <= touch;
    end

    // Glitch filter: update only after enough consecutive differing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_q <= 1'b0;
            cnt_q  <= '0;
        end else if (seed_q || cfg.filt == '0) begin
            qual_q <= raw;
            cnt_q  <= '0;
        end else if (raw == qual_q) begin
            cnt_q  <= '0;
        end else if (cnt_nx >= {1'b0, cfg.filt}) begin
            qual_q <= raw;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_nx[FILT_W-1:0];
        end
    end

    // Edge history: previous filtered sample, reseeded from the new pin.
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_q <= 1'b0;
        else if (seed_q) prev_q <= raw;
        else             prev_q <= qual_q;
    end

    assign evt = cfg.edge_mode && en && !seed_q &&
                 (cfg.act_low ? (!qual_q && prev_q) : (qual_q && !prev_q));

    // Sticky pending bit: reconfiguration clears, an event beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)            pend_q <= 1'b0;
        else if (!en || touch) pend_q <= 1'b0;
        else if (evt)          pend_q <= 1'b1;
        else if (clr)          pend_q <= 1'b0;
    end

    assign irq = en && !seed_q && (cfg.edge_mode ? pend_q : (qual_q ^ cfg.act_low));

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.edge_mode && pend_q && !clr && !touch && en) |=> pend_q);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt && !touch) |=> !pend_q);

    p_reseed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> (!pend_q && !irq));

    p_filter_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_q && cfg.filt >= 3'd2 && cnt_q == '0 && raw != qual_q) |=> $stable(qual_q));
endmodule

// File: rtl/gpio_irq_router.sv
// Top of the GPIO interrupt router: registers, synchroniser, eight channels.
// Assumes NUM_PINS is between 1 and 256; codes at or above it act as disabled.
module gpio_irq_router
    import gir_pkg::*;
#(
    parameter int NUM_PINS    = 255,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [4:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_PINS-1:0] gpio_in,
    output logic [7:0]          irq_out
);
    ch_cfg_t [NCH-1:0]   cfg;
    logic [NCH-1:0]      touch;
    logic [NCH-1:0]      clr;
    logic [NUM_PINS-1:0] pins_s;

    gir_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .cfg_o   (cfg),
        .touch_o (touch),
        .clr_o   (clr)
    );

    gir_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (gpio_in),
        .dout  (pins_s)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        gir_channel #(.NUM_PINS(NUM_PINS)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .pins_s (pins_s),
            .cfg    (cfg[c]),
            .touch  (touch[c]),
            .clr    (clr[c]),
            .irq    (irq_out[c])
        );

        p_off_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[c].pin == SEL_OFF) |-> !irq_out[c]);
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0));
endmodule

// File: tb/tb_gpio_irq_router.sv
module tb_gpio_irq_router;
    localparam int NP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NP-1:0] gpio_in = '0;
    logic [7:0]  irq_out;

    int tests = 0;
    int fails = 0;

    logic [31:0] sh_mode = 32'h0;
    logic [31:0] sh_lo   = 32'hFFFF_FFFF;
    logic [31:0] sh_hi   = 32'hFFFF_FFFF;
    logic [31:0] sh_filt = 32'h0;

    gpio_irq_router #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gpio_in(gpio_in), .irq_out(irq_out)
    );

    always #10 clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic set_sel(input int ch, input logic [7:0] code);
        if (ch < 4) begin
            sh_lo[8*ch +: 8] = code;
            wr(5'h04, sh_lo);
        end else begin
            sh_hi[8*(ch-4) +: 8] = code;
            wr(5'h08, sh_hi);
        end
    endtask

    task automatic set_mode(input int ch, input logic edg, input logic low);
        sh_mode[ch] = edg;
        sh_mode[16+ch] = low;
        wr(5'h00, sh_mode);
    endtask

    task automatic set_filt(input int ch, input logic [2:0] k);
        sh_filt[3*ch +: 3] = k;
        wr(5'h0C, sh_filt);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(5'h00, d); chk("R1 mode reset", d, 32'h0);
        rd(5'h04, d); chk("R1 sel lo reset", d, 32'hFFFF_FFFF);
        rd(5'h08, d); chk("R1 sel hi reset", d, 32'hFFFF_FFFF);
        rd(5'h0C, d); chk("R1 filt reset", d, 32'h0);
        chk("R1 irq reset", 32'(irq_out), 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, d); chk("R2 mode stored bits", d, 32'h00FF_00FF);
        wr(5'h00, 32'h0);
        wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, d); chk("R2 filt stored bits", d, 32'h00FF_FFFF);
        wr(5'h0C, 32'h0);
        rd(5'h10, d); chk("R2 clear reads zero", d, 32'h0);
        wr(5'h04, 32'h0302_0100); rd(5'h04, d); chk("R3 sel lo readback", d, 32'h0302_0100);
        wr(5'h04, 32'hFFFF_FFFF);
    endtask

    task automatic t_disabled();
        gpio_in = '1;
        step(4);
        chk("R3 all off stays low", 32'(irq_out), 32'h0);
        set_sel(0, 8'd20);
        set_sel(5, 8'd4);
        step(3);
        chk("R3 out-of-range off, ch5 field", 32'(irq_out), 32'h20);
        set_sel(0, 8'hFF);
        set_sel(5, 8'hFF);
        gpio_in = '0;
        step(3);
    endtask

    task automatic t_level();
        set_sel(1, 8'd2);
        set_mode(1, 1'b0, 1'b1);
        step(2);
        chk("R4 level-low active", 32'(irq_out[1]), 32'h1);
        gpio_in[2] = 1'b1;
        step(2);
        chk("R4 latency not yet", 32'(irq_out[1]), 32'h1);
        step(1);
        chk("R4 level-low released", 32'(irq_out[1]), 32'h0);
    endtask

    task automatic t_edge();
        set_sel(2, 8'd7);
        set_mode(2, 1'b1, 1'b0);
        step(2);
        chk("R5 idle", 32'(irq_out[2]), 32'h0);
        gpio_in[7] = 1'b1;
        step(3);
        chk("R5 latency not yet", 32'(irq_out[2]), 32'h0);
        step(1);
        chk("R5 rising pending", 32'(irq_out[2]), 32'h1);
        gpio_in[7] = 1'b0;
        step(4);
        chk("R5 sticky", 32'(irq_out[2]), 32'h1);
    endtask

    task automatic t_clear();
        wr(5'h10, 32'h0000_00FB);
        chk("R6 zero bit no effect", 32'(irq_out[2]), 32'h1);
        wr(5'h10, 32'h0000_0004);
        chk("R6 clear bit", 32'(irq_out[2]), 32'h0);
    endtask

    task automatic t_both();
        set_sel(3, 8'd9);
        set_sel(4, 8'd9);
        set_mode(3, 1'b1, 1'b1);
        set_mode(4, 1'b1, 1'b0);
        step(3);
        chk("R7 idle", 32'(irq_out[4:3]), 32'h0);
        gpio_in[9] = 1'b1;
        step(4);
        chk("R7 rise only", 32'(irq_out[4:3]), 32'h2);
        gpio_in[9] = 1'b0;
        step(4);
        chk("R7 both pending", 32'(irq_out[4:3]), 32'h3);
    endtask

    task automatic t_filter();
        logic seen;
        set_sel(6, 8'd11);
        set_filt(6, 3'd4);
        step(3);
        gpio_in[11] = 1'b1;
        step(3);
        gpio_in[11] = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            step(1);
            seen = seen | irq_out[6];
        end
        chk("R8 short pulse filtered", 32'(seen), 32'h0);
        gpio_in[11] = 1'b1;
        step(5);
        chk("R8 not before 2+k", 32'(irq_out[6]), 32'h0);
        step(1);
        chk("R8 passes after 2+k", 32'(irq_out[6]), 32'h1);
    endtask

    task automatic t_reseed();
        logic seen;
        set_sel(7, 8'd12);
        set_mode(7, 1'b1, 1'b0);
        step(3);
        gpio_in[12] = 1'b1;
        step(4);
        chk("R9 pending before switch", 32'(irq_out[7]), 32'h1);
        set_sel(7, 8'd13);
        chk("R9 select write clears", 32'(irq_out[7]), 32'h0);
        step(4);
        set_sel(7, 8'd12);
        seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step(1);
            seen = seen | irq_out[7];
        end
        chk("R9 no spurious edge", 32'(seen), 32'h0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_regs();
        t_disabled();
        t_level();
        t_edge();
        t_clear();
        t_both();
        t_filter();
        t_reseed();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule